// File: doc/BRIEF.md
# Parallel LCD Pixel Run Engine

This block is a bus master for a 16-bit 8080-style parallel link to an LCD controller that owns its own graphics RAM. A host hands it one request at a time on a valid/ready port. There are four kinds of request: write one controller register, read one controller register, write a run of pixels, and read a run of pixels. The engine turns each request into a string of bus beats on chip select, register select, the write and read strobes and a split data bus (output value, output enable, input value) that a pad ring joins into one bidirectional bus.

For pixel runs the engine does the cursor work itself. It writes the horizontal and vertical RAM address registers, selects the pixel RAM, and then streams the pixels. For reads it also throws away the stale first word. Before the coordinates reach the controller they are mirrored to suit the selected panel orientation. A run that is empty or that would pass the end of a line is dropped without any bus activity. The pixels are RGB565 words and go through unchanged.

Top module: `lcd_run_engine`

## Requirements
- R1: A register write (req_op 2'b00) makes two write beats: the index beat has lcd_rs low and data {8'h00, req_index}, and the value beat has lcd_rs high and data req_wdata.
- R2: A register read (req_op 2'b01) makes an index beat as in R1 and then one read beat with lcd_rs high. The word on lcd_dq_i during that strobe appears on rd_data, with rd_valid high for one cycle, in the cycle after the strobe ends.
- R3: Every beat keeps chip select low and both strobes high for SETUP_CYC cycles, and then holds exactly one strobe low for STROBE_CYC cycles. lcd_rs does not change during the beat. On writes, lcd_dq_o is held and lcd_dq_oe is high. On reads, lcd_dq_oe is low. The two strobes are never low together.
- R4: A pixel run (req_op 2'b10 write, 2'b11 read) starts with five write beats: index 0x0020, the horizontal address, index 0x0021, the vertical address, and index 0x0022.
- R5: A write run then makes req_len data write beats with lcd_rs high. Their data are the words taken on the pixel input handshake, in order, one handshake per beat.
- R6: A read run makes one read beat whose word is discarded, and then req_len read beats. Each of these delivers its word on rd_data with an rd_valid pulse, in order.
- R7: In portrait (orient 2'b00, and also 2'b11) the line is 240 pixels long, there are 320 lines, and the address registers receive the column and the row unchanged.
- R8: In reverse portrait (orient 2'b01) the sizes are those of R7. The horizontal address is 239-col and the vertical address is 319-row.
- R9: In landscape (orient 2'b10) the line is 320 pixels long and there are 240 lines. The horizontal address is col and the vertical address is 239-row.
- R10: A pixel run with req_len zero is accepted. No bus beat follows, no rd_valid pulse follows, and busy stays low.
- R11: A pixel run is handled like R10 when col+len exceeds the line length of the current orientation or when row is not below the line count. A run that ends exactly at the last pixel of the last line is carried out.
- R12: After reset and between requests, busy is low, req_ready is high, chip select and both strobes are high, and rd_valid is low. busy rises in the cycle after a request is accepted and stays high until the last strobe of that request has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| orient | input | 2 | Panel orientation, sampled when a request is accepted |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_op | input | 2 | 00 register write, 01 register read, 10 write run, 11 read run |
| req_index | input | 8 | Register index for register requests |
| req_wdata | input | 16 | Register value for a register write |
| req_row | input | 9 | Starting line of a run |
| req_col | input | 9 | Starting column of a run |
| req_len | input | 9 | Pixel count of a run |
| pix_in_valid | input | 1 | Pixel word offered for a write run |
| pix_in_ready | output | 1 | Engine waiting for the next pixel word |
| pix_in_data | input | 16 | RGB565 pixel word |
| rd_valid | output | 1 | One-cycle pulse with each word read back |
| rd_data | output | 16 | Word read from the controller |
| busy | output | 1 | A request is in progress |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_rs | output | 1 | Register select: low for index, high for data |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_dq_o | output | 16 | Data bus value driven by the engine |
| lcd_dq_oe | output | 1 | Data bus output enable |
| lcd_dq_i | input | 16 | Data bus value from the controller |

## Verification
A model of the controller returns a fresh, counting word on every read strobe. This tells a read run that consumes its dummy word apart from one that forwards it, because forwarding would shift every expected value by one. Write runs use pure red, green and blue pixels and then indexed words, so dropped, repeated or reordered pixels show up. Runs are issued in all three orientations, including corner coordinates that mirror to zero, which separates mirroring on one axis from mirroring on both. Empty runs and runs one pixel past the line end or one line past the bottom are paired with a run that ends exactly on the last pixel, so that an off-by-one bound check is caught.

// File: rtl/lcd_run_engine.sv
module lcd_run_engine #(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 2,
  parameter int PORT_W     = 240,
  parameter int PORT_H     = 320,
  parameter int CW         = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    orient,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [7:0]    req_index,
  input  logic [15:0]   req_wdata,
  input  logic [CW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  input  logic [CW-1:0] req_len,
  input  logic          pix_in_valid,
  output logic          pix_in_ready,
  input  logic [15:0]   pix_in_data,
  output logic          rd_valid,
  output logic [15:0]   rd_data,
  output logic          busy,
  output logic          lcd_cs_n,
  output logic          lcd_rs,
  output logic          lcd_wr_n,
  output logic          lcd_rd_n,
  output logic [15:0]   lcd_dq_o,
  output logic          lcd_dq_oe,
  input  logic [15:0]   lcd_dq_i
);
  localparam int TMAX = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int TW = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_SET = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] T_STB = TW'(STROBE_CYC - 1);
  localparam logic [CW:0]   LEN_S = (CW+1)'(PORT_W);
  localparam logic [CW:0]   LEN_L = (CW+1)'(PORT_H);
  localparam logic [CW-1:0] MAX_S = CW'(PORT_W - 1);
  localparam logic [CW-1:0] MAX_L = CW'(PORT_H - 1);

  typedef enum logic [1:0] {P_IDLE, P_WAIT, P_SETUP, P_STROBE} phase_t;
  typedef enum logic [3:0] {S_IDX_X, S_DAT_X, S_IDX_Y, S_DAT_Y, S_IDX_G,
                            S_DUMMY, S_PIX, S_IDX_R, S_DAT_R} step_t;

  phase_t phase;
  step_t  step;
  logic [TW-1:0] tmr;
  logic [1:0]    op_q;
  logic [7:0]    idx_q;
  logic [15:0]   wd_q, pix_q;
  logic [CW-1:0] x_q, y_q, rem_q;

  wire land = (orient == 2'b10);
  wire rev  = (orient == 2'b01);
  wire [CW:0] line_len = land ? LEN_L : LEN_S;
  wire [CW:0] line_cnt = land ? LEN_S : LEN_L;
  wire [CW:0] run_end  = {1'b0, req_col} + {1'b0, req_len};
  wire reject = req_op[1] && (req_len == '0 || run_end > line_len ||
                              {1'b0, req_row} >= line_cnt);
  wire [CW-1:0] map_x = rev ? MAX_S - req_col : req_col;
  wire [CW-1:0] map_y = rev ? MAX_L - req_row : (land ? MAX_S - req_row : req_row);

  wire beat_rd = (step == S_DUMMY) || (step == S_PIX && op_q == 2'b11) ||
                 (step == S_DAT_R && op_q == 2'b01);

  always_comb begin
    lcd_rs   = 1'b1;
    lcd_dq_o = '0;
    case (step)
      S_IDX_X: begin lcd_rs = 1'b0; lcd_dq_o = 16'h0020; end
      S_DAT_X: lcd_dq_o = 16'(x_q);
      S_IDX_Y: begin lcd_rs = 1'b0; lcd_dq_o = 16'h0021; end
      S_DAT_Y: lcd_dq_o = 16'(y_q);
      S_IDX_G: begin lcd_rs = 1'b0; lcd_dq_o = 16'h0022; end
      S_PIX:   lcd_dq_o = pix_q;
      S_IDX_R: begin lcd_rs = 1'b0; lcd_dq_o = {8'h00, idx_q}; end
      S_DAT_R: lcd_dq_o = wd_q;
      default: lcd_dq_o = '0;
    endcase
  end

  assign busy         = (phase != P_IDLE);
  assign req_ready    = !busy;
  assign pix_in_ready = (phase == P_WAIT);
  assign lcd_cs_n     = !busy;
  assign lcd_wr_n     = !(phase == P_STROBE && !beat_rd);
  assign lcd_rd_n     = !(phase == P_STROBE && beat_rd);
  assign lcd_dq_oe    = (phase == P_SETUP || phase == P_STROBE) && !beat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= P_IDLE;
      step     <= S_IDX_X;
      tmr      <= '0;
      op_q     <= '0;
      idx_q    <= '0;
      wd_q     <= '0;
      pix_q    <= '0;
      x_q      <= '0;
      y_q      <= '0;
      rem_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (phase)
        P_IDLE: if (req_valid && !reject) begin
          op_q  <= req_op;
          idx_q <= req_index;
          wd_q  <= req_wdata;
          x_q   <= map_x;
          y_q   <= map_y;
          rem_q <= req_len;
          step  <= req_op[1] ? S_IDX_X : S_IDX_R;
          phase <= P_SETUP;
          tmr   <= T_SET;
        end
        P_WAIT: if (pix_in_valid) begin
          pix_q <= pix_in_data;
          phase <= P_SETUP;
          tmr   <= T_SET;
        end
        P_SETUP: if (tmr == '0) begin
          phase <= P_STROBE;
          tmr   <= T_STB;
        end else tmr <= tmr - 1'b1;
        P_STROBE: if (tmr != '0) tmr <= tmr - 1'b1;
        else begin
          if (beat_rd) rd_data <= lcd_dq_i;
          rd_valid <= beat_rd && (step != S_DUMMY);
          phase <= P_SETUP;
          tmr   <= T_SET;
          case (step)
            S_IDX_X: step <= S_DAT_X;
            S_DAT_X: step <= S_IDX_Y;
            S_IDX_Y: step <= S_DAT_Y;
            S_DAT_Y: step <= S_IDX_G;
            S_IDX_G: if (op_q[0]) step <= S_DUMMY;
                     else begin step <= S_PIX; phase <= P_WAIT; end
            S_DUMMY: step <= S_PIX;
            S_PIX: begin
              rem_q <= rem_q - 1'b1;
              if (rem_q == 1) phase <= P_IDLE;
              else if (!op_q[0]) phase <= P_WAIT;
            end
            S_IDX_R: step <= S_DAT_R;
            default: phase <= P_IDLE;
          endcase
        end
        default: phase <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_run_engine_chk.sv
module lcd_run_engine_chk #(
  parameter int PORT_W = 240,
  parameter int CW     = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    orient,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_op,
  input logic [CW-1:0] req_col,
  input logic [CW-1:0] req_len,
  input logic          rd_valid,
  input logic          busy,
  input logic          lcd_cs_n,
  input logic          lcd_rs,
  input logic          lcd_wr_n,
  input logic          lcd_rd_n,
  input logic [15:0]   lcd_dq_o,
  input logic          lcd_dq_oe
);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lcd_wr_n && !lcd_rd_n));

  a_r3_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_wr_n |-> ($stable(lcd_dq_o) && $stable(lcd_rs) && lcd_dq_oe && !lcd_cs_n));

  a_r3_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rd_n |-> ($stable(lcd_rs) && lcd_rs && !lcd_dq_oe && !lcd_cs_n));

  a_r12_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lcd_cs_n && lcd_wr_n && lcd_rd_n && req_ready));

  a_r2_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!lcd_rd_n) && lcd_rd_n));

  a_r10_empty_run: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op[1] && req_len == '0) |=> !busy);

  a_r11_past_line: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op[1] && orient == 2'b00 &&
     ({1'b0, req_col} + {1'b0, req_len}) > (CW+1)'(PORT_W)) |=> !busy);
endmodule

bind lcd_run_engine lcd_run_engine_chk #(.PORT_W(PORT_W), .CW(CW)) u_chk (.*);

// File: tb/test_lcd_run_engine.sv
`timescale 1ns/1ps
module test_lcd_run_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] orient = 2'b00, req_op = '0;
  logic req_valid = 1'b0, pix_in_valid = 1'b0;
  logic [7:0] req_index = '0;
  logic [15:0] req_wdata = '0, pix_in_data = '0;
  logic [8:0] req_row = '0, req_col = '0, req_len = '0;
  logic req_ready, pix_in_ready, rd_valid, busy;
  logic lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_dq_oe;
  logic [15:0] rd_data, lcd_dq_o;
  logic [15:0] mem_word = 16'hA000;
  wire  [15:0] lcd_dq_i = mem_word;

  lcd_run_engine i_lcd_run_engine (.*);

  int errors = 0, checks = 0, strobes = 0, lowcnt = 0, hicnt = 0;
  logic [15:0] exp_word = 16'hA000;
  logic [18:0] exp_beat[$];
  string exp_tag[$];
  logic [15:0] exp_rd[$];
  string rd_tag[$];
  logic pwr = 1'b1, prd = 1'b1;

  task automatic chk(input bit ok, input string t, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor: bus beats and read results against the scoreboard
  always @(negedge clk) if (rst_n) begin
    if ((!lcd_wr_n && pwr) || (!lcd_rd_n && prd)) begin
      logic [18:0] act;
      strobes++;
      chk(hicnt == 2, "R3", "setup cycles", hicnt, 2);
      hicnt = 0;
      act = {lcd_cs_n, lcd_rs, !lcd_rd_n, lcd_rd_n ? lcd_dq_o : 16'h0};
      if (exp_beat.size() == 0) chk(0, "R3", "unexpected beat", act, 0);
      else begin
        logic [18:0] e;
        string t;
        e = exp_beat.pop_front();
        t = exp_tag.pop_front();
        chk(act == e, t, "bus beat {cs_n,rs,rd,data}", act, e);
      end
    end
    if (!lcd_wr_n || !lcd_rd_n) lowcnt++;
    else begin
      if (lowcnt != 0) chk(lowcnt == 2, "R3", "strobe width", lowcnt, 2);
      lowcnt = 0;
      if (!lcd_cs_n && !pix_in_ready) hicnt++;
      else hicnt = 0;
    end
    if (lcd_rd_n && !prd) mem_word = mem_word + 1'b1;
    if (rd_valid) begin
      if (exp_rd.size() == 0) chk(0, "R10", "unexpected rd_valid", rd_data, 0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_rd.pop_front();
        t = rd_tag.pop_front();
        chk(rd_data == e, t, "read word", rd_data, e);
      end
    end
    pwr = lcd_wr_n;
    prd = lcd_rd_n;
  end

  task automatic push_beat(input bit rs, input bit rd, input logic [15:0] d, input string t);
    exp_beat.push_back({1'b0, rs, rd, d});
    exp_tag.push_back(t);
  endtask

  task automatic push_read(input string t);
    push_beat(1, 1, 16'h0, t);
    exp_rd.push_back(exp_word);
    rd_tag.push_back(t);
    exp_word = exp_word + 1'b1;
  endtask

  function automatic logic [15:0] pix(input int i);
    case (i)
      0: return 16'hF800;
      1: return 16'h07E0;
      2: return 16'h001F;
      default: return 16'h1000 + 16'(i);
    endcase
  endfunction

  task automatic send_req(input logic [1:0] op, input logic [7:0] idx, input logic [15:0] wd,
                          input int row, input int col, input int len,
                          input bit exp_busy, input string t);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_index = idx; req_wdata = wd;
    req_row = 9'(row); req_col = 9'(col); req_len = 9'(len);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk(busy == exp_busy, exp_busy ? "R12" : t, "busy after accept", busy, exp_busy);
  endtask

  task automatic wait_idle(input string t);
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(exp_beat.size() == 0 && exp_rd.size() == 0, t, "all expected beats seen",
        exp_beat.size() + exp_rd.size(), 0);
    chk(lcd_cs_n && req_ready, "R12", "idle after request", {lcd_cs_n, req_ready}, 2'b11);
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [15:0] v);
    push_beat(0, 0, {8'h00, idx}, "R1");
    push_beat(1, 0, v, "R1");
    send_req(2'b00, idx, v, 0, 0, 0, 1, "R1");
    wait_idle("R1");
  endtask

  task automatic reg_rd(input logic [7:0] idx);
    push_beat(0, 0, {8'h00, idx}, "R2");
    push_read("R2");
    send_req(2'b01, idx, 16'h0, 0, 0, 0, 1, "R2");
    wait_idle("R2");
  endtask

  task automatic run(input bit rd, input int row, input int col, input int len, input string t);
    int x, y;
    case (orient)
      2'b01: begin x = 239 - col; y = 319 - row; end
      2'b10: begin x = col; y = 239 - row; end
      default: begin x = col; y = row; end
    endcase
    push_beat(0, 0, 16'h0020, "R4");
    push_beat(1, 0, 16'(x), t);
    push_beat(0, 0, 16'h0021, "R4");
    push_beat(1, 0, 16'(y), t);
    push_beat(0, 0, 16'h0022, "R4");
    if (rd) begin
      push_beat(1, 1, 16'h0, "R6");
      exp_word = exp_word + 1'b1;
      for (int i = 0; i < len; i++) push_read("R6");
    end else
      for (int i = 0; i < len; i++) push_beat(1, 0, pix(i), "R5");
    send_req({1'b1, rd}, 8'h00, 16'h0, row, col, len, 1, t);
    if (!rd)
      for (int i = 0; i < len; i++) begin
        pix_in_valid = 1'b1;
        pix_in_data = pix(i);
        while (!pix_in_ready) @(negedge clk);
        @(posedge clk);
        #1 pix_in_valid = 1'b0;
        @(negedge clk);
      end
    wait_idle(t);
  endtask

  task automatic reject(input bit rd, input int row, input int col, input int len, input string t);
    int s;
    s = strobes;
    send_req({1'b1, rd}, 8'h00, 16'h0, row, col, len, 0, t);
    repeat (12) @(negedge clk);
    chk(strobes == s, t, "strobes after rejected run", strobes - s, 0);
    chk(!busy && !lcd_cs_n == 1'b0, t, "bus idle after rejected run", {busy, lcd_cs_n}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy && req_ready, "R12", "reset busy/ready", {busy, req_ready}, 2'b01);
    chk(lcd_cs_n && lcd_wr_n && lcd_rd_n, "R12", "reset bus", {lcd_cs_n, lcd_wr_n, lcd_rd_n}, 3'b111);
    chk(!rd_valid, "R12", "reset rd_valid", rd_valid, 0);

    reg_wr(8'h07, 16'h0173);          // R1
    reg_rd(8'h00);                    // R2
    orient = 2'b00;
    run(0, 5, 10, 3, "R7");           // R4 R5 R7
    run(1, 0, 0, 4, "R7");            // R6 R7
    orient = 2'b01;
    run(0, 2, 3, 2, "R8");
    run(1, 319, 239, 1, "R8");
    orient = 2'b10;
    run(1, 10, 300, 20, "R9");
    run(0, 0, 0, 2, "R9");
    orient = 2'b00;
    reject(0, 0, 0, 0, "R10");
    reject(1, 7, 7, 0, "R10");
    reject(0, 0, 230, 11, "R11");
    reject(1, 320, 0, 1, "R11");
    orient = 2'b10;
    reject(1, 0, 300, 21, "R11");
    reject(0, 240, 0, 1, "R11");
    orient = 2'b00;
    run(0, 319, 239, 1, "R11");       // exact end of last line accepted
    reg_wr(8'h03, 16'h1030);          // R1 after rejections
    summary();
    $finish;
  end
endmodule